// File: doc/BRIEF.md
# Address-Match Breakpoint Trigger Unit

This block holds one debug trigger for a 64-bit core and compares it against the core's live memory traffic. Software reaches three registers through a small CSR port: a trigger select register, a control register and a match-address register. The control register reports a fixed trigger type in its top bits. It also holds a small set of enable bits that pick which access kinds (instruction fetch, load, store) may fire the trigger while the core runs in machine mode.

The unit watches the fetch, load and store address buses, each with its own valid strobe, together with the current privilege level. An enabled access whose address equals the programmed address raises a breakpoint exception request in the same cycle. The request carries the breakpoint cause code and the PC of the matching instruction. A handler can therefore step over the instruction by adding 4 to the saved PC. A matching store also raises a blocking signal that the core uses to squash the write before it commits, so memory keeps its old contents.

Software can find out which settings are supported by writing the control register and reading it back. Setting bits that the unit does not implement are dropped, so the read value differs from the written one.

Top module: `brk_trigger_unit`

## Requirements
- R1: After reset the select and match-address registers read 0, all control enable bits read 0, and no access of any kind produces `brk_req` or `store_block`.
- R2: A read of the control register (CSR address 1) always returns 4'h1 in bits [63:60] and zeros in bits [59:11]; writes to those bits have no effect on the value read.
- R3: The select register (CSR address 0) stores all 64 written bits, including a value with only bit 63 set, and keeps its value until it is written again.
- R4: Control bits [10:0] use this layout: bit 6 enables machine mode, bit 2 enables fetch, bit 1 enables store, bit 0 enables load. Every combination of these four bits reads back exactly as written.
- R5: A control write that sets any of bits 3, 4, 5, 7, 8, 9 or 10 stores those bits as 0. The four supported bits are kept as written, so the value read back differs from the value written.
- R6: CSR address 2 holds the full 64-bit match address. CSR address 3 reads 0, and a write to it changes no register.
- R7: A request needs all of the following: `priv_mode` == 2'b11 (machine), control bit 6 set, the access valid strobe high, and all 64 address bits equal to the match address.
- R8: With only fetch enabled (plus machine enable), a matching fetch requests a breakpoint and a load from the same address does not.
- R9: With only load enabled, a matching load requests a breakpoint and a store to the same address does not.
- R10: With store enabled, a matching store raises `brk_req` and `store_block` in the same cycle as the store's address and valid inputs. `store_block` is never high without such a store hit.
- R11: While `brk_req` is high, `brk_cause` is 3 and `brk_epc` is the PC of the matching instruction. For a fetch that PC is `fetch_addr`; for a load or store it is `load_pc` or `store_pc`. When several accesses hit at once, store wins over load and load wins over fetch. With no request, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr_en | input | 1 | Write strobe for the CSR port |
| csr_addr | input | 2 | Register index: 0 select, 1 control, 2 match address, 3 unused |
| csr_wdata | input | 64 | Write data |
| csr_rdata | output | 64 | Read data for `csr_addr`, combinational |
| priv_mode | input | 2 | Current privilege level, 2'b11 is machine |
| fetch_valid | input | 1 | Fetch address valid |
| fetch_addr | input | 64 | Fetch address (also the fetch PC) |
| load_valid | input | 1 | Load address valid |
| load_addr | input | 64 | Load data address |
| load_pc | input | 64 | PC of the load instruction |
| store_valid | input | 1 | Store address valid |
| store_addr | input | 64 | Store data address |
| store_pc | input | 64 | PC of the store instruction |
| brk_req | output | 1 | Breakpoint exception request |
| brk_cause | output | 4 | Exception cause code, 3 while requesting |
| brk_epc | output | 64 | PC to save for the trapping instruction |
| store_block | output | 1 | Suppress the current store's write |

## Verification
The embedded properties check on every cycle that a request never appears outside machine mode. They also check that a qualifying store always raises both the request and the block, that the block never appears without an enabled valid store, that the saved PC equals the fetch address when only a fetch is active, and that the select and control registers hold steady when they are not written. Other behaviour can only be shown by the bench's scenarios against its reference model. That covers probing support by readback of dropped bits, the fixed type field, isolation of fetch, load and store enables from one another on the same address, the 64-bit exactness of the compare, and the priority among simultaneous hits.

// File: rtl/brk_trig_pkg.sv
package brk_trig_pkg;

    localparam int CFG_W  = 11;
    localparam int TYPE_W = 4;

    localparam int BIT_LD = 0;
    localparam int BIT_ST = 1;
    localparam int BIT_EX = 2;
    localparam int BIT_MM = 6;

    localparam logic [CFG_W-1:0] CFG_LEGAL =
        CFG_W'((32'd1 << BIT_LD) | (32'd1 << BIT_ST) |
               (32'd1 << BIT_EX) | (32'd1 << BIT_MM));

    localparam logic [TYPE_W-1:0] TYPE_ADDR_BP = 4'd1;
    localparam logic [1:0]        PRIV_MACHINE = 2'b11;

    typedef enum logic [1:0] {
        REG_SEL   = 2'd0,
        REG_CTRL  = 2'd1,
        REG_MADDR = 2'd2,
        REG_NONE  = 2'd3
    } reg_sel_e;

    localparam int NUM_CH   = 3;
    localparam int CH_FETCH = 0;
    localparam int CH_LOAD  = 1;
    localparam int CH_STORE = 2;

endpackage

// File: rtl/brk_trig_regs.sv
module brk_trig_regs
    import brk_trig_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       reg_addr,
    input  logic [XLEN-1:0]  wdata,
    output logic [XLEN-1:0]  rdata,
    output logic [CFG_W-1:0] cfg,
    output logic [XLEN-1:0]  match_addr
);
    localparam int PAD_W = XLEN - TYPE_W - CFG_W;

    typedef struct packed {
        logic [XLEN-1:0]  sel;
        logic [CFG_W-1:0] cfg;
        logic [XLEN-1:0]  maddr;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (reg_sel_e'(reg_addr))
                REG_SEL:   st_d.sel   = wdata;
                REG_CTRL:  st_d.cfg   = wdata[CFG_W-1:0] & CFG_LEGAL;
                REG_MADDR: st_d.maddr = wdata;
                default:   st_d       = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (reg_sel_e'(reg_addr))
            REG_SEL:   rdata = st_q.sel;
            REG_CTRL:  rdata = {TYPE_ADDR_BP, {PAD_W{1'b0}}, st_q.cfg};
            REG_MADDR: rdata = st_q.maddr;
            default:   rdata = '0;
        endcase
    end

    assign cfg        = st_q.cfg;
    assign match_addr = st_q.maddr;

    assert_sel_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && reg_addr == REG_SEL) |=> $stable(st_q.sel));

    assert_ctrl_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && reg_addr == REG_CTRL) |=> $stable(cfg));

endmodule

// File: rtl/brk_trig_cmp.sv
module brk_trig_cmp #(
    parameter int XLEN = 64
) (
    input  logic            acc_valid,
    input  logic [XLEN-1:0] acc_addr,
    input  logic [XLEN-1:0] match_addr,
    input  logic            kind_en,
    input  logic            mode_ok,
    output logic            hit
);
    logic addr_eq;

    assign addr_eq = (acc_addr == match_addr);
    assign hit     = acc_valid && kind_en && mode_ok && addr_eq;

endmodule

// File: rtl/brk_trig_arb.sv
module brk_trig_arb
    import brk_trig_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter int CAUSE_W    = 4,
    parameter int CAUSE_CODE = 3
) (
    input  logic [NUM_CH-1:0]           ch_hit,
    input  logic [NUM_CH-1:0][XLEN-1:0] ch_pc,
    output logic                        req,
    output logic [CAUSE_W-1:0]          cause,
    output logic [XLEN-1:0]             epc,
    output logic                        block
);
    // Higher channel index is the older instruction, so it overrides.
    always_comb begin
        epc = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_hit[i]) epc = ch_pc[i];
        end
    end

    assign req   = |ch_hit;
    assign cause = req ? CAUSE_W'(CAUSE_CODE) : '0;
    assign block = ch_hit[CH_STORE];

endmodule

// File: rtl/brk_trigger_unit.sv
module brk_trigger_unit
    import brk_trig_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter int CAUSE_W    = 4,
    parameter int CAUSE_CODE = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               csr_wr_en,
    input  logic [1:0]         csr_addr,
    input  logic [XLEN-1:0]    csr_wdata,
    output logic [XLEN-1:0]    csr_rdata,
    input  logic [1:0]         priv_mode,
    input  logic               fetch_valid,
    input  logic [XLEN-1:0]    fetch_addr,
    input  logic               load_valid,
    input  logic [XLEN-1:0]    load_addr,
    input  logic [XLEN-1:0]    load_pc,
    input  logic               store_valid,
    input  logic [XLEN-1:0]    store_addr,
    input  logic [XLEN-1:0]    store_pc,
    output logic               brk_req,
    output logic [CAUSE_W-1:0] brk_cause,
    output logic [XLEN-1:0]    brk_epc,
    output logic               store_block
);
    logic [CFG_W-1:0]          cfg;
    logic [XLEN-1:0]           maddr;
    logic                      mode_ok;
    logic [NUM_CH-1:0]         ch_valid;
    logic [NUM_CH-1:0]         ch_en;
    logic [NUM_CH-1:0][XLEN-1:0] ch_addr;
    logic [NUM_CH-1:0][XLEN-1:0] ch_pc;
    logic [NUM_CH-1:0]         ch_hit;

    brk_trig_regs #(.XLEN(XLEN)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (csr_wr_en),
        .reg_addr   (csr_addr),
        .wdata      (csr_wdata),
        .rdata      (csr_rdata),
        .cfg        (cfg),
        .match_addr (maddr)
    );

    assign mode_ok = (priv_mode == PRIV_MACHINE) && cfg[BIT_MM];

    assign ch_valid[CH_FETCH] = fetch_valid;
    assign ch_addr[CH_FETCH]  = fetch_addr;
    assign ch_pc[CH_FETCH]    = fetch_addr;
    assign ch_en[CH_FETCH]    = cfg[BIT_EX];

    assign ch_valid[CH_LOAD]  = load_valid;
    assign ch_addr[CH_LOAD]   = load_addr;
    assign ch_pc[CH_LOAD]     = load_pc;
    assign ch_en[CH_LOAD]     = cfg[BIT_LD];

    assign ch_valid[CH_STORE] = store_valid;
    assign ch_addr[CH_STORE]  = store_addr;
    assign ch_pc[CH_STORE]    = store_pc;
    assign ch_en[CH_STORE]    = cfg[BIT_ST];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_cmp
        brk_trig_cmp #(.XLEN(XLEN)) u_cmp (
            .acc_valid  (ch_valid[g]),
            .acc_addr   (ch_addr[g]),
            .match_addr (maddr),
            .kind_en    (ch_en[g]),
            .mode_ok    (mode_ok),
            .hit        (ch_hit[g])
        );
    end

    brk_trig_arb #(
        .XLEN       (XLEN),
        .CAUSE_W    (CAUSE_W),
        .CAUSE_CODE (CAUSE_CODE)
    ) u_arb (
        .ch_hit (ch_hit),
        .ch_pc  (ch_pc),
        .req    (brk_req),
        .cause  (brk_cause),
        .epc    (brk_epc),
        .block  (store_block)
    );

    assert_req_mmode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> (priv_mode == PRIV_MACHINE));

    assert_store_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (store_valid && store_addr == maddr && cfg[BIT_ST] && cfg[BIT_MM] &&
         priv_mode == PRIV_MACHINE) |-> (store_block && brk_req));

    assert_block_needs_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
        store_block |-> (store_valid && cfg[BIT_ST]));

    assert_epc_fetch_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_req && !load_valid && !store_valid) |-> (brk_epc == fetch_addr));

endmodule

// File: tb/sim_brk_trigger_unit.sv
`timescale 1ns/1ps
module sim_brk_trigger_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_wr_en = 1'b0;
    logic [1:0]  csr_addr = '0;
    logic [63:0] csr_wdata = '0;
    logic [63:0] csr_rdata;
    logic [1:0]  priv_mode = 2'b11;
    logic        fetch_valid = 1'b0;
    logic [63:0] fetch_addr = '0;
    logic        load_valid = 1'b0;
    logic [63:0] load_addr = '0;
    logic [63:0] load_pc = '0;
    logic        store_valid = 1'b0;
    logic [63:0] store_addr = '0;
    logic [63:0] store_pc = '0;
    logic        brk_req;
    logic [3:0]  brk_cause;
    logic [63:0] brk_epc;
    logic        store_block;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    always #4 clk = ~clk;

    brk_trigger_unit u0 (
        .clk(clk), .rst_n(rst_n), .csr_wr_en(csr_wr_en), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .priv_mode(priv_mode),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .load_valid(load_valid), .load_addr(load_addr), .load_pc(load_pc),
        .store_valid(store_valid), .store_addr(store_addr), .store_pc(store_pc),
        .brk_req(brk_req), .brk_cause(brk_cause), .brk_epc(brk_epc),
        .store_block(store_block)
    );

    // Reference state, kept behaviourally from the requirements
    logic [63:0] m_sel, m_maddr;
    logic [10:0] m_cfg;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sel <= '0; m_maddr <= '0; m_cfg <= '0;
        end else if (csr_wr_en) begin
            if (csr_addr == 2'd0) m_sel <= csr_wdata;
            if (csr_addr == 2'd1) begin
                // R4/R5: only bits 6,2,1,0 survive a write
                m_cfg <= {4'b0, csr_wdata[6], 3'b0, csr_wdata[2:0]};
            end
            if (csr_addr == 2'd2) m_maddr <= csr_wdata;
        end
    end

    task automatic chk(string what, logic [63:0] got, logic [63:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, what, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            bit          in_m, hf, hl, hs, rq;
            logic [63:0] e_epc, e_rd;
            in_m = (priv_mode == 2'b11) && m_cfg[6];
            hf = in_m && fetch_valid && m_cfg[2] && (fetch_addr == m_maddr);
            hl = in_m && load_valid  && m_cfg[0] && (load_addr  == m_maddr);
            hs = in_m && store_valid && m_cfg[1] && (store_addr == m_maddr);
            rq = hf || hl || hs;
            e_epc = hs ? store_pc : hl ? load_pc : hf ? fetch_addr : 64'd0;
            case (csr_addr)
                2'd0:    e_rd = m_sel;
                2'd1:    e_rd = {4'h1, 49'd0, m_cfg};
                2'd2:    e_rd = m_maddr;
                default: e_rd = 64'd0;
            endcase
            chk("brk_req",     {63'd0, brk_req},     {63'd0, rq});
            chk("store_block", {63'd0, store_block}, {63'd0, hs});
            chk("brk_cause",   {60'd0, brk_cause},   rq ? 64'd3 : 64'd0);
            chk("brk_epc",     brk_epc,              e_epc);
            chk("csr_rdata",   csr_rdata,            e_rd);
        end
    end

    task automatic quiet();
        csr_wr_en = 0; fetch_valid = 0; load_valid = 0; store_valid = 0;
    endtask

    task automatic tick();
        @(posedge clk); #1;
        quiet();
    endtask

    task automatic wr(logic [1:0] a, logic [63:0] d);
        csr_wr_en = 1; csr_addr = a; csr_wdata = d; tick();
    endtask

    task automatic rd(logic [1:0] a);
        csr_addr = a; tick();
    endtask

    task automatic acc(bit f, logic [63:0] fa, bit l, logic [63:0] la,
                       logic [63:0] lp, bit s, logic [63:0] sa, logic [63:0] sp);
        fetch_valid = f; fetch_addr = fa;
        load_valid = l;  load_addr = la; load_pc = lp;
        store_valid = s; store_addr = sa; store_pc = sp;
        tick();
    endtask

    localparam logic [63:0] A  = 64'h8000_0000_0000_1234;
    localparam logic [63:0] PL = 64'h0000_0000_0000_4000;
    localparam logic [63:0] PS = 64'h0000_0000_0000_4004;

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1: reset values and no trigger activity
        cur_req = "R1";
        rd(2'd0); rd(2'd1); rd(2'd2);
        acc(1, 64'd0, 1, 64'd0, PL, 1, 64'd0, PS);
        // R3: select keeps every bit
        cur_req = "R3";
        wr(2'd0, 64'h8000_0000_0000_0000); rd(2'd0);
        wr(2'd0, 64'hDEAD_BEEF_0123_4567); rd(2'd0); rd(2'd1); rd(2'd0);
        // R2: type field fixed, upper bits not writable
        cur_req = "R2";
        wr(2'd1, 64'hFFFF_FFFF_FFFF_F800); rd(2'd1);
        // R6: match address and unused slot
        cur_req = "R6";
        wr(2'd2, A); rd(2'd2);
        wr(2'd3, 64'hFFFF_FFFF_FFFF_FFFF); rd(2'd3); rd(2'd0); rd(2'd1); rd(2'd2);
        // R4: every supported combination reads back exactly
        cur_req = "R4";
        for (int k = 0; k < 16; k++) begin
            wr(2'd1, {57'd0, k[3], 3'd0, k[2:0]}); rd(2'd1);
        end
        // R5: unsupported bits are dropped
        cur_req = "R5";
        for (int b = 3; b < 11; b++) begin
            if (b != 6) begin
                wr(2'd1, 64'h47 | (64'd1 << b)); rd(2'd1);
            end
        end
        wr(2'd1, 64'h7FF); rd(2'd1);
        // R8: fetch-only trigger
        cur_req = "R8";
        wr(2'd1, 64'h44); csr_addr = 2'd1;
        acc(1, A, 0, 0, 0, 0, 0, 0);
        acc(0, 0, 1, A, PL, 0, 0, 0);
        acc(0, 0, 0, 0, 0, 1, A, PS);
        // R7: qualification by mode, enable, valid and all address bits
        cur_req = "R7";
        acc(1, A ^ 64'h8000_0000_0000_0000, 0, 0, 0, 0, 0, 0);
        acc(1, A ^ 64'd1, 0, 0, 0, 0, 0, 0);
        acc(0, A, 0, 0, 0, 0, 0, 0);
        priv_mode = 2'b00; acc(1, A, 0, 0, 0, 0, 0, 0);
        priv_mode = 2'b01; acc(1, A, 0, 0, 0, 0, 0, 0);
        priv_mode = 2'b11;
        wr(2'd1, 64'h07); acc(1, A, 1, A, PL, 1, A, PS);
        // R9: load-only trigger
        cur_req = "R9";
        wr(2'd1, 64'h41);
        acc(0, 0, 1, A, PL, 0, 0, 0);
        acc(0, 0, 0, 0, 0, 1, A, PS);
        acc(1, A, 0, 0, 0, 0, 0, 0);
        // R10: store trigger blocks the write
        cur_req = "R10";
        wr(2'd1, 64'h42);
        acc(0, 0, 0, 0, 0, 1, A, PS);
        acc(0, 0, 1, A, PL, 0, 0, 0);
        acc(0, 0, 0, 0, 0, 1, A + 64'd4, PS);
        // R11: cause, saved PC and priority
        cur_req = "R11";
        wr(2'd1, 64'h47);
        acc(1, A, 1, A, PL, 1, A, PS);
        acc(1, A, 1, A, PL, 0, 0, 0);
        acc(1, A, 0, 0, 0, 1, A, PS);
        acc(1, A, 1, 64'd8, PL, 1, 64'd8, PS);
        acc(0, 0, 0, 0, 0, 0, 0, 0);
        done = 1'b1;
        summary();
    end

endmodule